// File: doc/BRIEF.md
# Dual-Profile Card Bus Cycle Timer

This block times one read or write access on a slow, card-style external bus. It accepts a request from the host side: an address, a byte or word size, a direction, a DMA flag and the area being addressed. It then walks the bus through four windows. First comes a setup window in which address, chip select and card enables are held before the strobe. Next comes the strobe window, in which RD or WE is driven and which is stretched by wait states. A hold window keeps the address and enables after the strobe. Last comes an idle gap before the next access may begin.

Two timing profiles are kept side by side. The most significant address bit picks one per access. Each profile holds a setup count, a hold count and a two-bit extra-wait code, and the code adds a coarse wait amount on top of a shared base wait count. The idle gap depends only on which of the two areas is addressed. A separate register mode for attached ATA devices chooses the card enables from the access size. In that mode a DMA transfer asserts neither card enable. In every mode a DMA transfer keeps DMA acknowledge asserted over the whole access window.

All timing inputs and request fields are captured on the clock that accepts the request. Software may therefore rewrite the timing registers at any time without disturbing an access already in flight.

Top module: `cardBusTimer`

## Requirements
- R1: When `reqAddr` bit ADDR_W-1 is 0, the access uses the A profile (setup, hold, extra-wait code). When the bit is 1, it uses the B profile.
- R2: The strobe window lasts `baseWait` + extra + 1 clocks, where the extra-wait code maps 0→0, 1→15, 2→30 and 3→50 clocks.
- R3: `csOut` and the selected card enables are asserted for exactly the profile setup count (0 to 15) of clocks before RD or WE first asserts.
- R4: `csOut` and the selected card enables stay asserted for exactly the profile hold count (0 to 15) of clocks after RD or WE negates.
- R5: After the hold window, the block stays busy with `csOut` low for `idleGap0` clocks when `areaSel` is 0 and for `idleGap1` clocks when it is 1. The address half has no effect on this gap.
- R6: `doneOut` is high for exactly one clock per access, and that clock is the last one in which `csOut` is high.
- R7: `rdOut` is asserted for reads (`reqWrite`=0) and `weOut` for writes, only inside the strobe window and never both at once. `addrOut` holds the request address throughout the window.
- R8: With `ataMode`=1 and no DMA, a byte access (`reqByte`=1) drives ce1=0 and ce2=1, and a word access drives ce1=1 and ce2=0.
- R9: With `reqDma`=1, `dackOut` is high in every clock from the first setup clock to the last hold clock and low outside that window. With `ataMode`=1 and `reqDma`=1, both card enables stay low.
- R10: With `ataMode`=0, a byte access drives ce1 only and a word access drives both ce1 and ce2, whatever the DMA flag.
- R11: Timing registers, area, mode and request fields are captured when an access starts. Changing them during the access does not alter its windows or enables.
- R12: After reset and whenever `busy` is low, all bus outputs are low. A request held high while busy does not disturb the running access, and it starts a new access on the first idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request, taken when not busy |
| reqAddr | input | ADDR_W | Access address; its top bit selects the profile |
| areaSel | input | 1 | Area addressed (0 or 1); selects the idle gap |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = word access |
| reqDma | input | 1 | Access is a DMA transfer |
| ataMode | input | 1 | ATA register mode enable |
| baseWait | input | CNT_W | Base wait count shared by both profiles |
| idleGap0 | input | CNT_W | Idle clocks after an access to area 0 |
| idleGap1 | input | CNT_W | Idle clocks after an access to area 1 |
| profAExtra | input | 2 | Profile A extra-wait code |
| profASetup | input | CNT_W | Profile A setup clocks |
| profAHold | input | CNT_W | Profile A hold clocks |
| profBExtra | input | 2 | Profile B extra-wait code |
| profBSetup | input | CNT_W | Profile B setup clocks |
| profBHold | input | CNT_W | Profile B hold clocks |
| busy | output | 1 | An access or its idle gap is in progress |
| addrOut | output | ADDR_W | Captured address |
| csOut | output | 1 | Chip select, high over the access window |
| ce1Out | output | 1 | Card enable 1 |
| ce2Out | output | 1 | Card enable 2 |
| rdOut | output | 1 | Read strobe |
| weOut | output | 1 | Write strobe |
| dackOut | output | 1 | DMA acknowledge |
| doneOut | output | 1 | One-clock pulse at the end of the hold window |

## Verification
The bench goes after the zero-length windows. With a setup or hold of 0, a design that still spent a clock in that window would lengthen chip select by one. If it skipped `doneOut` when the hold is empty, no completion pulse would be seen. It sweeps both address halves with the other profile loaded with mirrored values, so a swapped profile select or an idle gap keyed on the half rather than the area shows up as wrong window lengths. It also rewrites every register right after an access starts and holds a request through a busy period. A design that read live registers or accepted requests while busy would show stretched or doubled windows.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_GAP
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // latch request and timing on acceptance
    logic loadStrobe;  // load strobe length into the counter
    logic loadHold;    // load hold length
    logic loadGap;     // load idle gap length
    logic countDown;   // decrement the counter
    logic window;      // chip select window active
    logic strobeOn;    // RD or WE window active
    logic doneNow;     // last clock of the window
  } ctrlStrobe_t;

  // Coarse extra-wait code to clock count
  function automatic logic [6:0] extraWait(input logic [1:0] code);
    case (code)
      2'd0:    extraWait = 7'd0;
      2'd1:    extraWait = 7'd15;
      2'd2:    extraWait = 7'd30;
      default: extraWait = 7'd50;
    endcase
  endfunction

endpackage

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              areaSel,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic              reqDma,
  input  logic              ataMode,
  input  logic [CNT_W-1:0]  baseWait,
  input  logic [CNT_W-1:0]  idleGap0,
  input  logic [CNT_W-1:0]  idleGap1,
  input  logic [1:0]        profAExtra,
  input  logic [CNT_W-1:0]  profASetup,
  input  logic [CNT_W-1:0]  profAHold,
  input  logic [1:0]        profBExtra,
  input  logic [CNT_W-1:0]  profBSetup,
  input  logic [CNT_W-1:0]  profBHold,
  output logic              cntZero,
  output logic              rawSetupZero,
  output logic              latHoldZero,
  output logic              latGapZero,
  output logic [ADDR_W-1:0] addrOut,
  output logic              csOut,
  output logic              ce1Out,
  output logic              ce2Out,
  output logic              rdOut,
  output logic              weOut,
  output logic              dackOut,
  output logic              doneOut
);

  localparam int WAIT_W = $clog2((1 << CNT_W) + 52);
  localparam int NPROF  = 2;

  // Profile fields gathered into arrays indexed by the address half
  logic [1:0]       extraArr [NPROF];
  logic [CNT_W-1:0] setupArr [NPROF];
  logic [CNT_W-1:0] holdArr  [NPROF];

  assign extraArr[0] = profAExtra;
  assign extraArr[1] = profBExtra;
  assign setupArr[0] = profASetup;
  assign setupArr[1] = profBSetup;
  assign holdArr[0]  = profAHold;
  assign holdArr[1]  = profBHold;

  logic             half;
  logic [1:0]       selExtra;
  logic [CNT_W-1:0] selSetup;
  logic [CNT_W-1:0] selHold;
  logic [CNT_W-1:0] selGap;
  logic [WAIT_W-1:0] rawWait;

  assign half     = reqAddr[ADDR_W-1];
  assign selExtra = extraArr[half];
  assign selSetup = setupArr[half];
  assign selHold  = holdArr[half];
  assign selGap   = areaSel ? idleGap1 : idleGap0;
  assign rawWait  = WAIT_W'(baseWait) + WAIT_W'(extraWait(selExtra)) + WAIT_W'(1);
  assign rawSetupZero = (selSetup == '0);

  // Captured per-access state
  logic [WAIT_W-1:0] latWait;
  logic [CNT_W-1:0]  latHold;
  logic [CNT_W-1:0]  latGap;
  logic              latWrite;
  logic              latByte;
  logic              latDma;
  logic              latAta;
  logic [ADDR_W-1:0] latAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latWait  <= '0;
      latHold  <= '0;
      latGap   <= '0;
      latWrite <= 1'b0;
      latByte  <= 1'b0;
      latDma   <= 1'b0;
      latAta   <= 1'b0;
      latAddr  <= '0;
    end else if (stb.capture) begin
      latWait  <= rawWait;
      latHold  <= selHold;
      latGap   <= selGap;
      latWrite <= reqWrite;
      latByte  <= reqByte;
      latDma   <= reqDma;
      latAta   <= ataMode;
      latAddr  <= reqAddr;
    end
  end

  assign latHoldZero = (latHold == '0);
  assign latGapZero  = (latGap == '0);

  // Shared down counter for all windows
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.capture) begin
      cnt <= rawSetupZero ? (rawWait - WAIT_W'(1))
                          : (WAIT_W'(selSetup) - WAIT_W'(1));
    end else if (stb.loadStrobe) begin
      cnt <= latWait - WAIT_W'(1);
    end else if (stb.loadHold) begin
      cnt <= WAIT_W'(latHold) - WAIT_W'(1);
    end else if (stb.loadGap) begin
      cnt <= WAIT_W'(latGap) - WAIT_W'(1);
    end else if (stb.countDown) begin
      cnt <= cnt - WAIT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  // Card enable pattern by mode, size and DMA flag
  logic ce1Sel;
  logic ce2Sel;

  always_comb begin
    if (latAta) begin
      if (latDma) begin
        ce1Sel = 1'b0;
        ce2Sel = 1'b0;
      end else begin
        ce1Sel = !latByte;
        ce2Sel = latByte;
      end
    end else begin
      ce1Sel = 1'b1;
      ce2Sel = !latByte;
    end
  end

  assign addrOut = latAddr;
  assign csOut   = stb.window;
  assign ce1Out  = stb.window & ce1Sel;
  assign ce2Out  = stb.window & ce2Sel;
  assign rdOut   = stb.strobeOn & !latWrite;
  assign weOut   = stb.strobeOn & latWrite;
  assign dackOut = stb.window & latDma;
  assign doneOut = stb.doneNow;

endmodule

// File: rtl/cbt_ctrl.sv
module cbt_ctrl
  import cbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cntZero,
  input  logic        rawSetupZero,
  input  logic        latHoldZero,
  input  logic        latGapZero,
  output ctrlStrobe_t stb,
  output logic        busy
);

  phase_t phase;
  phase_t nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  always_comb begin
    nextPhase = phase;
    stb       = '0;
    case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          nextPhase   = rawSetupZero ? PH_STROBE : PH_SETUP;
        end
      end
      PH_SETUP: begin
        stb.window = 1'b1;
        if (cntZero) begin
          stb.loadStrobe = 1'b1;
          nextPhase      = PH_STROBE;
        end else begin
          stb.countDown = 1'b1;
        end
      end
      PH_STROBE: begin
        stb.window   = 1'b1;
        stb.strobeOn = 1'b1;
        if (cntZero) begin
          if (latHoldZero) begin
            stb.doneNow = 1'b1;
            if (latGapZero) begin
              nextPhase = PH_IDLE;
            end else begin
              stb.loadGap = 1'b1;
              nextPhase   = PH_GAP;
            end
          end else begin
            stb.loadHold = 1'b1;
            nextPhase    = PH_HOLD;
          end
        end else begin
          stb.countDown = 1'b1;
        end
      end
      PH_HOLD: begin
        stb.window = 1'b1;
        if (cntZero) begin
          stb.doneNow = 1'b1;
          if (latGapZero) begin
            nextPhase = PH_IDLE;
          end else begin
            stb.loadGap = 1'b1;
            nextPhase   = PH_GAP;
          end
        end else begin
          stb.countDown = 1'b1;
        end
      end
      PH_GAP: begin
        if (cntZero) nextPhase = PH_IDLE;
        else         stb.countDown = 1'b1;
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/cardBusTimer.sv
module cardBusTimer
  import cbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              areaSel,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic              reqDma,
  input  logic              ataMode,
  input  logic [CNT_W-1:0]  baseWait,
  input  logic [CNT_W-1:0]  idleGap0,
  input  logic [CNT_W-1:0]  idleGap1,
  input  logic [1:0]        profAExtra,
  input  logic [CNT_W-1:0]  profASetup,
  input  logic [CNT_W-1:0]  profAHold,
  input  logic [1:0]        profBExtra,
  input  logic [CNT_W-1:0]  profBSetup,
  input  logic [CNT_W-1:0]  profBHold,
  output logic              busy,
  output logic [ADDR_W-1:0] addrOut,
  output logic              csOut,
  output logic              ce1Out,
  output logic              ce2Out,
  output logic              rdOut,
  output logic              weOut,
  output logic              dackOut,
  output logic              doneOut
);

  ctrlStrobe_t stb;
  logic cntZero;
  logic rawSetupZero;
  logic latHoldZero;
  logic latGapZero;

  cbt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .cntZero      (cntZero),
    .rawSetupZero (rawSetupZero),
    .latHoldZero  (latHoldZero),
    .latGapZero   (latGapZero),
    .stb          (stb),
    .busy         (busy)
  );

  cbt_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqAddr      (reqAddr),
    .areaSel      (areaSel),
    .reqWrite     (reqWrite),
    .reqByte      (reqByte),
    .reqDma       (reqDma),
    .ataMode      (ataMode),
    .baseWait     (baseWait),
    .idleGap0     (idleGap0),
    .idleGap1     (idleGap1),
    .profAExtra   (profAExtra),
    .profASetup   (profASetup),
    .profAHold    (profAHold),
    .profBExtra   (profBExtra),
    .profBSetup   (profBSetup),
    .profBHold    (profBHold),
    .cntZero      (cntZero),
    .rawSetupZero (rawSetupZero),
    .latHoldZero  (latHoldZero),
    .latGapZero   (latGapZero),
    .addrOut      (addrOut),
    .csOut        (csOut),
    .ce1Out       (ce1Out),
    .ce2Out       (ce2Out),
    .rdOut        (rdOut),
    .weOut        (weOut),
    .dackOut      (dackOut),
    .doneOut      (doneOut)
  );

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic csOut,
  input logic ce1Out,
  input logic ce2Out,
  input logic rdOut,
  input logic weOut,
  input logic dackOut,
  input logic doneOut
);

  // R7: read and write strobes never together
  assert_rw_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rdOut && weOut));

  // R7: a strobe only inside the chip select window
  assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdOut || weOut) |-> csOut);

  // R6: completion is a single-clock pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R6: completion marks the last chip select clock
  assert_done_last_cs_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> csOut ##1 !csOut);

  // R9: acknowledge confined to the window
  assert_dack_in_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    dackOut |-> csOut);

  // R3: card enables only inside the window
  assert_ce_in_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ce1Out || ce2Out) |-> csOut);

  // R12: quiet bus while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(csOut || dackOut || rdOut || weOut || doneOut));

endmodule

bind cardBusTimer cbt_checker u_cbtChecker (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .csOut   (csOut),
  .ce1Out  (ce1Out),
  .ce2Out  (ce2Out),
  .rdOut   (rdOut),
  .weOut   (weOut),
  .dackOut (dackOut),
  .doneOut (doneOut)
);

// File: tb/test_cardBusTimer.sv
module test_cardBusTimer;

  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              areaSel = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqByte = 1'b0;
  logic              reqDma = 1'b0;
  logic              ataMode = 1'b0;
  logic [CNT_W-1:0]  baseWait = '0;
  logic [CNT_W-1:0]  idleGap0 = '0;
  logic [CNT_W-1:0]  idleGap1 = '0;
  logic [1:0]        profAExtra = '0;
  logic [CNT_W-1:0]  profASetup = '0;
  logic [CNT_W-1:0]  profAHold = '0;
  logic [1:0]        profBExtra = '0;
  logic [CNT_W-1:0]  profBSetup = '0;
  logic [CNT_W-1:0]  profBHold = '0;
  logic              busy;
  logic [ADDR_W-1:0] addrOut;
  logic              csOut, ce1Out, ce2Out, rdOut, weOut, dackOut, doneOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  cardBusTimer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_cardBusTimer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .areaSel(areaSel), .reqWrite(reqWrite), .reqByte(reqByte),
    .reqDma(reqDma), .ataMode(ataMode), .baseWait(baseWait),
    .idleGap0(idleGap0), .idleGap1(idleGap1),
    .profAExtra(profAExtra), .profASetup(profASetup), .profAHold(profAHold),
    .profBExtra(profBExtra), .profBSetup(profBSetup), .profBHold(profBHold),
    .busy(busy), .addrOut(addrOut), .csOut(csOut), .ce1Out(ce1Out),
    .ce2Out(ce2Out), .rdOut(rdOut), .weOut(weOut), .dackOut(dackOut),
    .doneOut(doneOut)
  );

  function automatic int extraOf(input int code);
    case (code)
      0: return 0;
      1: return 15;
      2: return 30;
      default: return 50;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Runs one access from the current inputs and measures every window.
  task automatic runTrip(input int eS, input int eW, input int eH, input int eG,
                         input bit eCe1, input bit eCe2, input bit eDack,
                         input bit midChange, input bit holdReq);
    logic [ADDR_W-1:0] a;
    bit wr;
    bit seen;
    int s, w, h, g, dn, donePos, lastCs, idx, ceBad, dackBad, dirBad, addrBad;
    a = reqAddr; wr = reqWrite; seen = 0;
    s = 0; w = 0; h = 0; g = 0; dn = 0; donePos = -1; lastCs = -2; idx = 0;
    ceBad = 0; dackBad = 0; dirBad = 0; addrBad = 0;
    @(negedge clk) reqValid = 1'b1;
    @(negedge clk) if (!holdReq) reqValid = 1'b0;
    while (busy && idx < 500) begin
      if (csOut) begin
        if (rdOut || weOut) begin
          w++; seen = 1;
          if (rdOut !== !wr || weOut !== wr) dirBad++;
        end else if (!seen) s++;
        else h++;
        lastCs = idx;
        if (ce1Out !== eCe1 || ce2Out !== eCe2) ceBad++;
        if (dackOut !== eDack) dackBad++;
        if (addrOut !== a) addrBad++;
      end else begin
        g++;
        if (dackOut || ce1Out || ce2Out || rdOut || weOut) ceBad++;
      end
      if (doneOut) begin dn++; donePos = idx; end
      if (midChange && idx == 0) begin
        // R11: scramble everything once the access is under way
        reqAddr = ~reqAddr; areaSel = ~areaSel; reqWrite = ~reqWrite;
        reqByte = ~reqByte; reqDma = ~reqDma; ataMode = ~ataMode;
        baseWait = ~baseWait; idleGap0 = ~idleGap0; idleGap1 = ~idleGap1;
        profAExtra = ~profAExtra; profASetup = ~profASetup; profAHold = ~profAHold;
        profBExtra = ~profBExtra; profBSetup = ~profBSetup; profBHold = ~profBHold;
      end
      idx++;
      @(negedge clk);
    end
    chk("R3 setup clocks", s, eS);
    chk("R2 strobe clocks", w, eW);
    chk("R4 hold clocks", h, eH);
    chk("R5 idle gap clocks", g, eG);
    chk("R6 done pulses", dn, 1);
    chk("R6 done on last cs clock", donePos, lastCs);
    chk("R8 R10 card enables", ceBad, 0);
    chk("R9 dack window", dackBad, 0);
    chk("R7 strobe direction", dirBad, 0);
    chk("R7 address held", addrBad, 0);
    if (holdReq) begin
      // R12: held request starts the next access on the first idle clock
      @(negedge clk);
      chk("R12 held request restarts", int'(busy), 1);
      reqValid = 1'b0;
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset outputs", int'({csOut, ce1Out, ce2Out, rdOut, weOut, dackOut, doneOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 idle outputs", int'({csOut, rdOut, weOut, dackOut, doneOut}), 0);

    // R1 R2 R3 R4 R5: sweep setup, hold, codes, halves and areas
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 4; k++) begin
        int code, hv, base, g0, g1;
        bit half, area;
        code = (s + k) % 4;
        hv   = (s * 7 + k * 5) % 16;
        base = (s * 3 + k) % 16;
        g0   = s % 5;
        g1   = 6 + (s % 4);
        half = k[0];
        area = k[1];
        reqAddr  = {half, 7'(s * 9 + k)};
        areaSel  = area;
        reqWrite = k[0] ^ s[0];
        reqByte  = 1'b0; reqDma = 1'b0; ataMode = 1'b0;
        baseWait = CNT_W'(base);
        idleGap0 = CNT_W'(g0); idleGap1 = CNT_W'(g1);
        if (!half) begin
          profAExtra = 2'(code); profASetup = CNT_W'(s); profAHold = CNT_W'(hv);
          profBExtra = 2'(3 - code); profBSetup = CNT_W'(15 - s); profBHold = CNT_W'(15 - hv);
        end else begin
          profBExtra = 2'(code); profBSetup = CNT_W'(s); profBHold = CNT_W'(hv);
          profAExtra = 2'(3 - code); profASetup = CNT_W'(15 - s); profAHold = CNT_W'(15 - hv);
        end
        runTrip(s, base + extraOf(code) + 1, hv, area ? g1 : g0,
                1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      end
    end

    // R8 R9 R10: every mode, size and DMA combination
    for (int m = 0; m < 8; m++) begin
      bit ata, byt, dma, e1, e2;
      ata = m[2]; byt = m[1]; dma = m[0];
      reqAddr = 8'h15; areaSel = 1'b0; reqWrite = m[0];
      reqByte = byt; reqDma = dma; ataMode = ata;
      baseWait = 4'd2; idleGap0 = 4'd1;
      profAExtra = 2'd0; profASetup = 4'd1; profAHold = 4'd2;
      if (ata) begin e1 = !dma && !byt; e2 = !dma && byt; end
      else     begin e1 = 1'b1;         e2 = !byt;        end
      runTrip(1, 3, 2, 1, e1, e2, dma, 1'b0, 1'b0);
    end

    // R11: registers rewritten just after the access starts
    reqAddr = 8'h83; areaSel = 1'b1; reqWrite = 1'b1; reqByte = 1'b1;
    reqDma = 1'b0; ataMode = 1'b1; baseWait = 4'd4;
    idleGap0 = 4'd9; idleGap1 = 4'd3;
    profAExtra = 2'd3; profASetup = 4'd12; profAHold = 4'd11;
    profBExtra = 2'd1; profBSetup = 4'd2; profBHold = 4'd5;
    runTrip(2, 4 + 15 + 1, 5, 3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

    // R12: request held through the busy period
    reqAddr = 8'h40; areaSel = 1'b0; reqWrite = 1'b0; reqByte = 1'b0;
    reqDma = 1'b1; ataMode = 1'b0; baseWait = 4'd0;
    idleGap0 = 4'd2; idleGap1 = 4'd7;
    profAExtra = 2'd0; profASetup = 4'd0; profAHold = 4'd0;
    profBExtra = 2'd2; profBSetup = 4'd9; profBHold = 4'd9;
    runTrip(0, 1, 0, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);

    @(negedge clk);
    chk("R12 idle after held request", int'({busy, csOut, dackOut}), 0);
    summary();
  end

endmodule